// File: doc/BRIEF.md
# Command Ring Fetch Engine

This block sits on the controller side of a command path. Software places 32-bit commands in a circular buffer in system memory and moves a write pointer forward. The engine reads each new entry from memory and hands it to a downstream consumer over a valid/ready stream. After each command is accepted, the engine moves its own read pointer forward by one.

Software reaches the engine through a small register window of four 32-bit words. Each word has byte-lane strobes, so the byte offset of a field is 4 × word index plus 8-bit lane number.

| Word | Lanes | Contents |
|------|-------|----------|
| 0 | all | Low half of the buffer base |
| 1 | all | High half of the buffer base |
| 2 | 0 | Write pointer |
| 2 | 2 | Engine read pointer |
| 2 | bit 31 | Pointer-reset flag |
| 3 | 0 | Control |
| 3 | 1 | Status |
| 3 | 2 | Size |

The entry count is 2, 16 or 256, selected from the sizes the instance advertises. Pointers wrap modulo the selected count. The run bit reads back the engine's real activity, so software can poll it after starting or stopping the engine.

Top module: `cmd_ring_fetch`

## Requirements
- R1: After reset:
  - word 2 reads 0.
  - word 3 reads 0x0072_0000 with the default capability 3'b111. The size byte is capabilities in bits [6:4] and the select in bits [1:0], where 10 = 256 entries is the default when supported.
  - Control reads 0, status reads 0.
  - `cmd_valid` and `mem_req_valid` are low.
- R2: Bits [6:0] of word 0 always read as zero, whatever is written.
- R3: The fetch address is base + 4 × ((read pointer + 1) mod size). It is held stable while `mem_req_ready` is low. The word returned by memory is presented unchanged on `cmd_data`.
- R4: No memory read is issued while the read pointer equals the write pointer (masked to the size). Entries are fetched in order, and the read pointer (word 2 bits [23:16]) advances by one per accepted command, wrapping modulo the size.
- R5: At most one entry is in flight: no new read request from a request handshake until the resulting command is accepted.
- R6: While `cmd_ready` is low, `cmd_valid` and `cmd_data` hold and the read pointer does not change.
- R7: Control bit 1 is the run bit.
  - Writing 0 stops new fetches at an entry boundary.
  - The bit reads back 1 until any in-flight entry has been accepted, then reads 0.
  - While it reads 0, no request or command is presented.
- R8: The pointer reset is a two-phase handshake on word 2 bit 31.
  - Writing 1 forces the read pointer to 0, and the bit then reads 1.
  - Writing 0 makes it read 0 again.
  - No fetch happens while the bit is held at 1.
- R9: Size select encodings are 00 = 2, 01 = 16 and 10 = 256 entries. A write of an unadvertised or reserved (11) select is ignored.
- R10: Writes to the base address words or the size select are ignored while the run bit is set or reads 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_word | input | 2 | Register word index (byte offset / 4) |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_strb | input | 4 | Byte-lane enables for the write |
| reg_wr_data | input | 32 | Write data |
| reg_rd_data | output | 32 | Read data of the addressed word (combinational) |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Returned entry |
| cmd_valid | output | 1 | Command available |
| cmd_ready | input | 1 | Consumer takes the command |
| cmd_data | output | 32 | Command word |

## Verification
The delicate overlap is a stop request landing while a fetched command sits on the output stream, held back by a low `cmd_ready`. The bench provokes it by clearing the run bit during the back-pressure and reading the control word before and after releasing the command. The run bit must still read 1 while the entry is held and read 0 once it has drained. The request count must show that no further memory read followed. A second overlap raises the pointer-reset flag while the write pointer shows pending work and the run bit is set, and confirms that no fetch starts until the flag is cleared.

// File: rtl/cmd_ring_pkg.sv
package cmd_ring_pkg;

   typedef enum logic [1:0] {
      FS_IDLE,
      FS_REQ,
      FS_WAIT,
      FS_SHOW
   } fetch_state_t;

   localparam int PTR_W = 8;

   localparam logic [1:0] W_BASE_LO = 2'd0;
   localparam logic [1:0] W_BASE_HI = 2'd1;
   localparam logic [1:0] W_PTRS    = 2'd2;
   localparam logic [1:0] W_CTRL    = 2'd3;

   // wrap mask for a size select code
   function automatic logic [PTR_W-1:0] size_mask(input logic [1:0] sel);
      case (sel)
         2'b00:   size_mask = 8'h01;
         2'b01:   size_mask = 8'h0F;
         default: size_mask = 8'hFF;
      endcase
   endfunction

   function automatic logic [31:0] byte_merge(input logic [31:0] old_v,
                                              input logic [31:0] new_v,
                                              input logic [3:0]  strb);
      logic [31:0] r;
      r = old_v;
      for (int i = 0; i < 4; i++)
         if (strb[i]) r[8*i +: 8] = new_v[8*i +: 8];
      return r;
   endfunction

endpackage

// File: rtl/cmd_ring_regs.sv
module cmd_ring_regs
   import cmd_ring_pkg::*;
#(
   parameter int         ADDR_W    = 64,
   parameter logic [2:0] SIZE_CAPS = 3'b111
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        reg_word,
   input  logic              reg_wr_en,
   input  logic [3:0]        reg_wr_strb,
   input  logic [31:0]       reg_wr_data,
   output logic [31:0]       reg_rd_data,
   input  logic              run_act,
   input  logic [PTR_W-1:0]  rd_ptr,
   input  logic              rst_done,
   output logic [ADDR_W-1:0] base_addr,
   output logic [PTR_W-1:0]  wr_ptr,
   output logic [1:0]        size_sel,
   output logic              run_req,
   output logic              ptr_rst_hold
);

   localparam int HI_W = ADDR_W - 32;
   localparam logic [1:0] DEF_SEL = SIZE_CAPS[2] ? 2'b10 :
                                    SIZE_CAPS[1] ? 2'b01 : 2'b00;

   if (ADDR_W <= 32 || ADDR_W > 64) begin : g_bad_addr_w
      $error("cmd_ring_regs: ADDR_W must lie in 33..64");
   end
   if (SIZE_CAPS == 3'b000) begin : g_bad_caps
      $error("cmd_ring_regs: at least one size must be advertised");
   end

   // select codes this instance accepts
   logic [3:0] sel_ok;
   for (genvar g = 0; g < 3; g++) begin : g_sel_ok
      assign sel_ok[g] = SIZE_CAPS[g];
   end
   assign sel_ok[3] = 1'b0;

   logic [31:0] base_lo_q, base_hi_q;
   logic        locked;
   logic [31:0] lo_new;

   assign locked = run_req | run_act;
   assign lo_new = byte_merge(base_lo_q, reg_wr_data, reg_wr_strb);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_lo_q    <= '0;
         base_hi_q    <= '0;
         wr_ptr       <= '0;
         size_sel     <= DEF_SEL;
         run_req      <= 1'b0;
         ptr_rst_hold <= 1'b0;
      end else if (reg_wr_en) begin
         case (reg_word)
            W_BASE_LO: if (!locked) base_lo_q <= {lo_new[31:7], 7'b0};
            W_BASE_HI: if (!locked) base_hi_q <= byte_merge(base_hi_q, reg_wr_data, reg_wr_strb);
            W_PTRS: begin
               if (reg_wr_strb[0]) wr_ptr       <= reg_wr_data[7:0];
               if (reg_wr_strb[3]) ptr_rst_hold <= reg_wr_data[31];
            end
            default: begin
               if (reg_wr_strb[0]) run_req <= reg_wr_data[1];
               if (reg_wr_strb[2] && !locked && sel_ok[reg_wr_data[17:16]])
                  size_sel <= reg_wr_data[17:16];
            end
         endcase
      end
   end

   assign base_addr = {base_hi_q[HI_W-1:0], base_lo_q};

   always_comb begin
      case (reg_word)
         W_BASE_LO: reg_rd_data = base_lo_q;
         W_BASE_HI: reg_rd_data = base_hi_q;
         W_PTRS:    reg_rd_data = {rst_done, 7'b0, rd_ptr, 8'h00, wr_ptr};
         default:   reg_rd_data = {8'h00, 1'b0, SIZE_CAPS, 2'b00, size_sel,
                                   8'h00, 6'b0, run_act, 1'b0};
      endcase
   end

endmodule

// File: rtl/cmd_ring_fetch_eng.sv
module cmd_ring_fetch_eng
   import cmd_ring_pkg::*;
#(
   parameter int ADDR_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [PTR_W-1:0]  wr_ptr,
   input  logic [1:0]        size_sel,
   input  logic              run_req,
   input  logic              ptr_rst_hold,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [ADDR_W-1:0] mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [31:0]       mem_rsp_data,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [31:0]       cmd_data,
   output logic [PTR_W-1:0]  rd_ptr,
   output logic              run_act,
   output logic              rst_done
);

   fetch_state_t     state;
   logic [PTR_W-1:0] mask, nxt_ptr;
   logic             empty, idle;

   assign mask    = size_mask(size_sel);
   assign nxt_ptr = (rd_ptr + 8'd1) & mask;
   assign empty   = (rd_ptr == (wr_ptr & mask));
   assign idle    = (state == FS_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= FS_IDLE;
         rd_ptr   <= '0;
         run_act  <= 1'b0;
         rst_done <= 1'b0;
         cmd_data <= '0;
      end else begin
         rst_done <= ptr_rst_hold & idle;
         case (state)
            FS_IDLE: begin
               run_act <= run_req;
               if (ptr_rst_hold)
                  rd_ptr <= '0;
               else if (run_act && run_req && !empty)
                  state <= FS_REQ;
            end
            FS_REQ:  if (mem_req_ready) state <= FS_WAIT;
            FS_WAIT: if (mem_rsp_valid) begin
               cmd_data <= mem_rsp_data;
               state    <= FS_SHOW;
            end
            default: if (cmd_ready) begin
               rd_ptr <= nxt_ptr;
               state  <= FS_IDLE;
            end
         endcase
      end
   end

   assign mem_req_valid = (state == FS_REQ);
   assign cmd_valid     = (state == FS_SHOW);
   assign mem_req_addr  = base_addr + {{(ADDR_W-PTR_W-2){1'b0}}, nxt_ptr, 2'b00};

endmodule

// File: rtl/cmd_ring_fetch.sv
module cmd_ring_fetch
   import cmd_ring_pkg::*;
#(
   parameter int         ADDR_W    = 64,
   parameter logic [2:0] SIZE_CAPS = 3'b111
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        reg_word,
   input  logic              reg_wr_en,
   input  logic [3:0]        reg_wr_strb,
   input  logic [31:0]       reg_wr_data,
   output logic [31:0]       reg_rd_data,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [ADDR_W-1:0] mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [31:0]       mem_rsp_data,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [31:0]       cmd_data
);

   logic [ADDR_W-1:0] base_addr;
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic [1:0]        size_sel;
   logic              run_req, run_act, ptr_rst_hold, rst_done;

   cmd_ring_regs #(.ADDR_W(ADDR_W), .SIZE_CAPS(SIZE_CAPS)) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .reg_word     (reg_word),
      .reg_wr_en    (reg_wr_en),
      .reg_wr_strb  (reg_wr_strb),
      .reg_wr_data  (reg_wr_data),
      .reg_rd_data  (reg_rd_data),
      .run_act      (run_act),
      .rd_ptr       (rd_ptr),
      .rst_done     (rst_done),
      .base_addr    (base_addr),
      .wr_ptr       (wr_ptr),
      .size_sel     (size_sel),
      .run_req      (run_req),
      .ptr_rst_hold (ptr_rst_hold)
   );

   cmd_ring_fetch_eng #(.ADDR_W(ADDR_W)) u_eng (
      .clk           (clk),
      .rst_n         (rst_n),
      .base_addr     (base_addr),
      .wr_ptr        (wr_ptr),
      .size_sel      (size_sel),
      .run_req       (run_req),
      .ptr_rst_hold  (ptr_rst_hold),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_req_addr  (mem_req_addr),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data  (mem_rsp_data),
      .cmd_valid     (cmd_valid),
      .cmd_ready     (cmd_ready),
      .cmd_data      (cmd_data),
      .rd_ptr        (rd_ptr),
      .run_act       (run_act),
      .rst_done      (rst_done)
   );

endmodule

// File: rtl/cmd_ring_chk.sv
module cmd_ring_chk #(
   parameter int ADDR_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        reg_word,
   input logic [31:0]       reg_rd_data,
   input logic              mem_req_valid,
   input logic              mem_req_ready,
   input logic [ADDR_W-1:0] mem_req_addr,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic [31:0]       cmd_data
);

   // an entry is in flight from its request handshake to its command handshake
   logic in_flight;
   always_ff @(posedge clk) begin
      if (!rst_n)                             in_flight <= 1'b0;
      else if (mem_req_valid && mem_req_ready) in_flight <= 1'b1;
      else if (cmd_valid && cmd_ready)         in_flight <= 1'b0;
   end

   assert_single_outstanding_R5: assert property (@(posedge clk) disable iff (!rst_n)
      in_flight |-> !mem_req_valid);

   assert_cmd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data)));

   assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   assert_base_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_word == 2'd0) |-> (reg_rd_data[6:0] == 7'd0));

   assert_stopped_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_word == 2'd3 && !reg_rd_data[1]) |-> (!mem_req_valid && !cmd_valid));

endmodule

bind cmd_ring_fetch cmd_ring_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .reg_word      (reg_word),
   .reg_rd_data   (reg_rd_data),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_req_addr  (mem_req_addr),
   .cmd_valid     (cmd_valid),
   .cmd_ready     (cmd_ready),
   .cmd_data      (cmd_data)
);

// File: tb/cmd_ring_fetch_tb_top.sv
`timescale 1ns/1ps
module cmd_ring_fetch_tb_top;

   localparam int ADDR_W = 64;
   localparam logic [63:0] BASE = 64'h0000_0001_0000_1000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [1:0]        reg_word = '0;
   logic              reg_wr_en = 1'b0;
   logic [3:0]        reg_wr_strb = '0;
   logic [31:0]       reg_wr_data = '0;
   logic [31:0]       reg_rd_data;
   logic              mem_req_valid;
   logic              mem_req_ready = 1'b1;
   logic [ADDR_W-1:0] mem_req_addr;
   logic              mem_rsp_valid;
   logic [31:0]       mem_rsp_data;
   logic              cmd_valid;
   logic              cmd_ready = 1'b0;
   logic [31:0]       cmd_data;

   int          checks = 0;
   int          fails  = 0;
   int          req_cnt;
   logic [63:0] last_addr;

   always #2.5 clk = ~clk;

   cmd_ring_fetch #(.ADDR_W(ADDR_W), .SIZE_CAPS(3'b111)) dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .reg_word      (reg_word),
      .reg_wr_en     (reg_wr_en),
      .reg_wr_strb   (reg_wr_strb),
      .reg_wr_data   (reg_wr_data),
      .reg_rd_data   (reg_rd_data),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_req_addr  (mem_req_addr),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data  (mem_rsp_data),
      .cmd_valid     (cmd_valid),
      .cmd_ready     (cmd_ready),
      .cmd_data      (cmd_data)
   );

   function automatic logic [31:0] mem_word(input logic [63:0] a);
      return a[31:0] ^ 32'h5A00_0000;
   endfunction

   // one-cycle-latency memory
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_rsp_valid <= 1'b0;
         mem_rsp_data  <= '0;
         req_cnt       <= 0;
         last_addr     <= '0;
      end else begin
         mem_rsp_valid <= 1'b0;
         if (mem_req_valid && mem_req_ready) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= mem_word(mem_req_addr);
            last_addr     <= mem_req_addr;
            req_cnt       <= req_cnt + 1;
         end
      end
   end

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [1:0] w, input logic [31:0] d, input logic [3:0] s);
      @(negedge clk);
      reg_word = w; reg_wr_data = d; reg_wr_strb = s; reg_wr_en = 1'b1;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic reg_rd(input logic [1:0] w, output logic [31:0] d);
      @(negedge clk);
      reg_word = w;
      #1 d = reg_rd_data;
   endtask

   task automatic idle_cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   // wait for a command, accept it, compare data and fetch address
   task automatic take_cmd(input string tag, input logic [63:0] exp_addr);
      bit seen = 0;
      for (int i = 0; i < 400 && !seen; i++) begin
         @(negedge clk);
         if (cmd_valid) seen = 1;
      end
      if (!seen) begin
         check({tag, " command timeout"}, 64'd0, 64'd1);
      end else begin
         check({tag, " fetch address"}, last_addr, exp_addr);
         check({tag, " command data"}, {32'd0, cmd_data}, {32'd0, mem_word(exp_addr)});
         cmd_ready = 1'b1;
         @(negedge clk);
         cmd_ready = 1'b0;
      end
   endtask

   task automatic wait_valid();
      for (int i = 0; i < 400 && !cmd_valid; i++) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      reg_rd(2'd2, d); check("R1 pointers word", d, 32'h0);
      reg_rd(2'd3, d); check("R1 control/size word", d, 32'h0072_0000);
      check("R1 cmd_valid", cmd_valid, 1'b0);
      check("R1 mem_req_valid", mem_req_valid, 1'b0);
   endtask

   task automatic t_base();
      logic [31:0] d;
      reg_wr(2'd0, 32'hFFFF_FFFF, 4'hF);
      reg_rd(2'd0, d); check("R2 low base alignment", d, 32'hFFFF_FF80);
      reg_wr(2'd0, BASE[31:0], 4'hF);
      reg_wr(2'd1, BASE[63:32], 4'hF);
      reg_rd(2'd0, d); check("R2 low base", d, BASE[31:0]);
   endtask

   task automatic t_size_sel();
      logic [31:0] d;
      reg_wr(2'd3, 32'h0003_0000, 4'b0100);
      reg_rd(2'd3, d); check("R9 reserved select ignored", d, 32'h0072_0000);
      reg_wr(2'd3, 32'h0001_0000, 4'b0100);
      reg_rd(2'd3, d); check("R9 select 16 entries", d, 32'h0071_0000);
   endtask

   task automatic t_fetch();
      logic [31:0] d;
      reg_wr(2'd2, 32'd3, 4'b0001);
      reg_wr(2'd3, 32'h2, 4'b0001);
      for (int k = 1; k <= 3; k++) take_cmd("R3 in-order fetch", BASE + 64'(4 * k));
      reg_rd(2'd2, d); check("R4 read pointer after 3", d[23:16], 8'd3);
      idle_cycles(10);
      check("R4 no fetch when empty", req_cnt, 3);
   endtask

   task automatic t_backpressure();
      logic [31:0] d, held;
      reg_wr(2'd2, 32'd4, 4'b0001);
      wait_valid();
      held = cmd_data;
      idle_cycles(5);
      check("R6 valid held", cmd_valid, 1'b1);
      check("R6 data held", cmd_data, held);
      reg_rd(2'd2, d); check("R6 pointer frozen", d[23:16], 8'd3);
      take_cmd("R6 released", BASE + 64'd16);
      reg_rd(2'd2, d); check("R6 pointer after accept", d[23:16], 8'd4);
   endtask

   task automatic t_wrap();
      logic [31:0] d;
      reg_wr(2'd2, 32'd1, 4'b0001);
      for (int i = 0; i < 13; i++)
         take_cmd("R4 wrap mod 16", BASE + 64'(4 * ((5 + i) & 15)));
      reg_rd(2'd2, d); check("R4 pointer wrapped", d[23:16], 8'd1);
   endtask

   task automatic t_lock();
      logic [31:0] d;
      reg_wr(2'd0, 32'h0000_2000, 4'hF);
      reg_wr(2'd3, 32'h0000_0002, 4'b0101);
      reg_rd(2'd0, d); check("R10 base locked", d, BASE[31:0]);
      reg_rd(2'd3, d); check("R10 size locked", d, 32'h0071_0002);
   endtask

   task automatic t_stop();
      logic [31:0] d;
      int r0;
      reg_wr(2'd2, 32'd4, 4'b0001);
      wait_valid();
      r0 = req_cnt;
      reg_wr(2'd3, 32'h0, 4'b0001);
      reg_rd(2'd3, d); check("R7 run reads 1 while entry held", d[1], 1'b1);
      take_cmd("R7 held entry", BASE + 64'd8);
      idle_cycles(3);
      reg_rd(2'd3, d); check("R7 run reads 0 after drain", d[1], 1'b0);
      idle_cycles(10);
      check("R7 no fetch after stop", req_cnt, r0);
      reg_rd(2'd2, d); check("R7 pointer at boundary", d[23:16], 8'd2);
   endtask

   task automatic t_ptr_reset();
      logic [31:0] d;
      int r0;
      reg_wr(2'd2, 32'h8000_0000, 4'b1000);
      idle_cycles(2);
      reg_rd(2'd2, d); check("R8 reset done reads 1", d, 32'h8000_0004);
      r0 = req_cnt;
      reg_wr(2'd3, 32'h2, 4'b0001);
      idle_cycles(10);
      check("R8 no fetch while held", req_cnt, r0);
      reg_wr(2'd2, 32'h0, 4'b1000);
      idle_cycles(1);
      reg_rd(2'd2, d); check("R8 clear reads 0", d[31], 1'b0);
      for (int k = 1; k <= 4; k++) take_cmd("R8 fetch after reset", BASE + 64'(4 * k));
   endtask

   task automatic t_size2();
      logic [31:0] d;
      reg_wr(2'd3, 32'h0, 4'b0001);
      idle_cycles(3);
      reg_wr(2'd3, 32'h0, 4'b0100);
      reg_rd(2'd3, d); check("R9 select 2 entries", d, 32'h0070_0000);
      reg_wr(2'd2, 32'h8000_0000, 4'b1000);
      idle_cycles(2);
      reg_wr(2'd2, 32'h0, 4'b1000);
      reg_wr(2'd2, 32'd1, 4'b0001);
      reg_wr(2'd3, 32'h2, 4'b0001);
      take_cmd("R9 size 2 entry 1", BASE + 64'd4);
      reg_wr(2'd2, 32'd0, 4'b0001);
      take_cmd("R9 size 2 entry 0", BASE);
      reg_rd(2'd2, d); check("R9 pointer wraps mod 2", d[23:16], 8'd0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_base();
      t_size_sel();
      t_fetch();
      t_backpressure();
      t_wrap();
      t_lock();
      t_stop();
      t_ptr_reset();
      t_size2();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #500000;
      fails++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule